// File: doc/BRIEF.md
# SPI Slave Pause Gate

This block sits between the SPI pins of a slave and its shift logic and gives the bus master a way to suspend a transfer without losing its place. A registered pause flag holds the transfer's state. While the flag is set, serial clock edges are hidden from the shift logic and the serial output is released. When the flag clears, shifting picks up at the same bit. The block acts only while chip select is active (low).

The three pin inputs are chip select, serial clock and pause request. All three are active low where a polarity applies, and each passes through a synchroniser to the system clock. The block turns each qualified serial clock edge into a one-cycle enable pulse. A rising edge gives the receive sample pulse and a falling edge gives the transmit shift pulse. The shift logic asks to drive the serial output through a request input, and the block returns the output enable for the pad. The pause request is level sensitive but can change the pause state only while the serial clock is low. A change made while the clock is high is held off until the clock falls.

Top module: `spi_hold_gate`

## Requirements
- R1: While selected and not paused, each serial clock rising edge produces exactly one `rx_sample_en` pulse and each falling edge exactly one `tx_shift_en` pulse; the two pulses never occur in the same cycle.
- R2: The pause state changes only while the serial clock is low; a pause request level change made while the clock is high has no effect until the falling edge, and that falling edge is qualified with the new level.
- R3: While paused, serial clock edges produce no pulses and SI is not sampled; after the pause the pulse count continues from the same bit, so a transfer yields one pulse per edge outside the pause.
- R4: `so_oe` equals `so_drive_req` while selected and not paused, and is 0 while paused.
- R5: While chip select is high, no pulse is produced, `so_oe` is 0 and the pause request has no effect (`pause_active` stays 0).
- R6: Chip select going high clears an active pause, so the next transfer starts unpaused.
- R7: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sel_n | input | 1 | Chip select pin, active low |
| spi_clk | input | 1 | Serial clock pin |
| spi_pause_n | input | 1 | Pause request pin, active low |
| so_drive_req | input | 1 | Shift logic wants to drive the serial output |
| rx_sample_en | output | 1 | One-cycle pulse per qualified rising serial clock edge |
| tx_shift_en | output | 1 | One-cycle pulse per qualified falling serial clock edge |
| so_oe | output | 1 | Serial output pad enable |
| pause_active | output | 1 | Transfer is currently paused |

## Verification
Two events can land in the same cycle: a pause level change that was held off during the clock high phase, and the falling clock edge that releases it. In that cycle the block has to decide whether the edge yields a shift pulse. The bench provokes this by changing the pause pin in the middle of a high phase, both to enter a pause and to leave one. It then judges the outcome from the shift-pulse counts and from the `pause_active` and `so_oe` levels sampled before and after the fall. A second directed case deselects the chip while a pause is active, so the pause clear and the deselect happen together.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    // Registered state of the pause gate
    typedef struct packed {
        logic paused;
        logic rx_en;
        logic tx_en;
        logic oe;
    } gate_st_t;

    localparam gate_st_t GATE_RST = '{paused: 1'b0, rx_en: 1'b0, tx_en: 1'b0, oe: 1'b0};

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], pin_i[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
                else        chain_q <= chain_d;
            end

            assign lvl_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = lvl_i;
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= RST_VAL;
        else        lvl_q <= lvl_d;
    end

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck_lvl,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic pause_n_lvl,
    input  logic so_req,
    output logic rx_en,
    output logic tx_en,
    output logic oe,
    output logic paused
);

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // pause level is only sampled in the clock low phase; while high it is held
        if (!sel)          st_d.paused = 1'b0;
        else if (!sck_lvl) st_d.paused = ~pause_n_lvl;
        else               st_d.paused = st_q.paused;
        // edges are qualified against the pause value of the same cycle
        st_d.rx_en = sck_rise & sel & ~st_d.paused;
        st_d.tx_en = sck_fall & sel & ~st_d.paused;
        st_d.oe    = so_req   & sel & ~st_d.paused;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GATE_RST;
        else        st_q <= st_d;
    end

    assign rx_en  = st_q.rx_en;
    assign tx_en  = st_q.tx_en;
    assign oe     = st_q.oe;
    assign paused = st_q.paused;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rx_en && st_q.tx_en)); // R1

    AST_PAUSE_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.paused != $past(st_q.paused)) && $past(sel)) |-> !$past(sck_lvl)); // R2

    AST_NO_PULSE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.paused |-> (!st_q.rx_en && !st_q.tx_en)); // R3

    AST_OE_OFF_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.paused |-> !st_q.oe); // R4

    AST_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> (!st_q.rx_en && !st_q.tx_en && !st_q.oe)); // R5

    AST_CLEAR_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !st_q.paused); // R6

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sel_n,
    input  logic spi_clk,
    input  logic spi_pause_n,
    input  logic so_drive_req,
    output logic rx_sample_en,
    output logic tx_shift_en,
    output logic so_oe,
    output logic pause_active
);

    localparam int PIN_W = 3;
    // bit 2: select (idle high), bit 1: clock (idle low), bit 0: pause (idle high)
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b101;

    logic [PIN_W-1:0] pin_lvl;
    logic             sck_rise, sck_fall;

    spi_hold_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({spi_sel_n, spi_clk, spi_pause_n}),
        .lvl_o (pin_lvl)
    );

    spi_hold_edge #(
        .RST_VAL (PIN_IDLE[1])
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl[1]),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    spi_hold_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (~pin_lvl[2]),
        .sck_lvl     (pin_lvl[1]),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .pause_n_lvl (pin_lvl[0]),
        .so_req      (so_drive_req),
        .rx_en       (rx_sample_en),
        .tx_en       (tx_shift_en),
        .oe          (so_oe),
        .paused      (pause_active)
    );

endmodule

// File: tb/spi_hold_gate_tb.sv
module spi_hold_gate_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b0, pause_n = 1'b1, so_req = 1'b0;
    logic rx_en, tx_en, oe, pact;
    int   n_run = 0, n_fail = 0;
    int   rx_cnt = 0, tx_cnt = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    spi_hold_gate u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(sel_n), .spi_clk(sck),
        .spi_pause_n(pause_n), .so_drive_req(so_req),
        .rx_sample_en(rx_en), .tx_shift_en(tx_en), .so_oe(oe), .pause_active(pact)
    );

    always @(negedge clk) begin
        if (rx_en) rx_cnt <= rx_cnt + 1;
        if (tx_en) tx_cnt <= tx_cnt + 1;
    end

    // vector: [9:2] per-period pause mask (bit i pauses SCK period i), [1] so_drive_req, [0] spare
    localparam int NV = 6;
    localparam logic [9:0] VEC [NV] = '{
        10'b00000000_1_0, 10'b00010000_1_0, 10'b00111000_1_0,
        10'b10000001_0_0, 10'b01010101_1_0, 10'b11111111_1_0
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clr_cnt;
        wclk(2);
        rx_cnt = 0;
        tx_cnt = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wclk(3);
        // R7 reset state
        chk("R7 rx", rx_en, 0); chk("R7 tx", tx_en, 0);
        chk("R7 oe", oe, 0);    chk("R7 pause", pact, 0);
        rst_n = 1'b1;
        wclk(5);

        // table walk: R1, R3, R4
        for (int v = 0; v < NV; v++) begin
            logic [7:0] m;
            m = VEC[v][9:2];
            so_req = VEC[v][1];
            sel_n = 1'b0;
            wclk(8);
            clr_cnt();
            for (int i = 0; i < 8; i++) begin
                pause_n = ~m[i];
                wclk(10);
                sck = 1'b1;
                wclk(6);
                chk("R4 oe", oe, (so_req && !m[i]) ? 1 : 0);
                chk("R3 pause", pact, m[i] ? 1 : 0);
                wclk(4);
                sck = 1'b0;
                wclk(6);
            end
            pause_n = 1'b1;
            wclk(8);
            chk("R1/R3 rx count", rx_cnt, 8 - $countones(m));
            chk("R1/R3 tx count", tx_cnt, 8 - $countones(m));
            sel_n = 1'b1;
            wclk(8);
        end

        // R2: pause entered during high phase applies at the fall
        so_req = 1'b1; pause_n = 1'b1; sel_n = 1'b0;
        wclk(8); clr_cnt();
        sck = 1'b1; wclk(3); pause_n = 1'b0; wclk(7);
        chk("R2 held oe", oe, 1);
        chk("R2 held pause", pact, 0);
        sck = 1'b0; wclk(6);
        chk("R2 applied pause", pact, 1);
        chk("R2 applied oe", oe, 0);
        chk("R2 fall suppressed", tx_cnt, 0);
        chk("R2 rx", rx_cnt, 1);
        // release during high phase: the fall carries a shift pulse
        sck = 1'b1; wclk(4); pause_n = 1'b1; wclk(6);
        chk("R2 release held", pact, 1);
        sck = 1'b0; wclk(6);
        chk("R2 release applied", pact, 0);
        chk("R2 release oe", oe, 1);
        chk("R2 release rx", rx_cnt, 1);
        chk("R2 release tx", tx_cnt, 1);
        sel_n = 1'b1; wclk(8);

        // R6: deselect clears a pause; R5: pause pin ignored while deselected
        sel_n = 1'b0; wclk(6); pause_n = 1'b0; wclk(8);
        chk("R6 paused", pact, 1);
        sel_n = 1'b1; wclk(6);
        chk("R6 cleared", pact, 0);
        clr_cnt();
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; wclk(6); sck = 1'b0; wclk(6);
        end
        chk("R5 pause ignored", pact, 0);
        chk("R5 oe", oe, 0);
        chk("R5 rx", rx_cnt, 0);
        chk("R5 tx", tx_cnt, 0);
        pause_n = 1'b1; sel_n = 1'b0; wclk(8); clr_cnt();
        sck = 1'b1; wclk(8); sck = 1'b0; wclk(8);
        chk("R6 next rx", rx_cnt, 1);
        chk("R6 next tx", tx_cnt, 1);
        sel_n = 1'b1; wclk(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule